// File: doc/BRIEF.md
# Maskable Interrupt Entry Sequencer

This block carries out the entry steps a 16-bit accumulator-style processor takes once it has accepted a maskable interrupt. A one-cycle start pulse captures the processor context. The captured context is the program counter, the program bank, the status byte, the stack pointer and a flag for the 8-bit-compatible (emulation) mode. The block then writes the return context to the stack one byte per clock. It then fetches the handler address as a little-endian word through a byte read port. A control bit can replace that fetch with an address held in two external registers.

When the sequence finishes, a one-cycle done pulse marks the handler address, the bank (forced to zero), the adjusted status byte, the final stack pointer and the extra cycle cost as valid. These outputs keep their values until the next sequence completes. The emulation-mode path and the native path differ in three ways: how many bytes are pushed, where the vector is read from, and the cost reported.

Top module: `irq_entry_seq`

## Requirements
- R1: In native mode (`emu_mode`=0) the block writes four bytes in consecutive cycles: the bank, then PC[15:8], then PC[7:0], then the status byte. The addresses are SP, SP-1, SP-2 and SP-3, using 16-bit arithmetic that wraps.
- R2: In emulation mode (`emu_mode`=1) the block writes no bank byte. It writes PC[15:8], then PC[7:0], then the status byte at {0x01, SP[7:0]}, {0x01, SP[7:0]-1} and {0x01, SP[7:0]-2}. Only the low byte counts down, modulo 256, and the high address byte stays 0x01.
- R3: Without override, the block reads the vector low byte at 0xFFEE and the high byte at 0xFFEF in native mode. In emulation mode it reads 0xFFFE and then 0xFFFF. `new_pc` is {high, low}.
- R4: When `ovr_en`=1 and bit 6 of `ovr_ctrl` is 1 at start, the block makes no vector reads and `new_pc` = {`ovr_hi`, `ovr_lo`}. If either condition is false, the memory vector is used.
- R5: At done, `new_bank` is 0x00. `new_status` equals the captured status with bit 3 (decimal) cleared and bit 2 (interrupt disable) set, and every other bit unchanged.
- R6: At done, `cycle_cost` is 8 for a native-mode entry and 6 for an emulation-mode entry.
- R7: At done, `new_sp` is the stack pointer after the last push: SP-4 in native mode, or {0x01, SP[7:0]-3} in emulation mode.
- R8: `done` is high for exactly one cycle, in the cycle right after the last memory access, and the sequence makes one memory access in every cycle before it. Counting the start sampling edge as 0, done is seen in cycle (number of accesses + 1).
- R9: While busy, `start` is ignored, and so are changes on the context inputs. No more than one access happens per cycle, and `mem_wr_en` and `mem_rd_en` are never high together.
- R10: After a synchronous reset, `busy`, `done`, `mem_wr_en` and `mem_rd_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept-interrupt pulse, sampled while idle |
| emu_mode | input | 1 | 1 = emulation mode, 0 = native mode |
| pc_in | input | 16 | Current program counter |
| bank_in | input | 8 | Current program bank |
| status_in | input | 8 | Current status byte |
| sp_in | input | 16 | Current stack pointer |
| ovr_en | input | 1 | Override feature enable |
| ovr_ctrl | input | 8 | Override control register (bit 6 selects override) |
| ovr_lo | input | 8 | Override vector low byte |
| ovr_hi | input | 8 | Override vector high byte |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the read address |
| mem_wr_en | output | 1 | Write strobe |
| mem_rd_en | output | 1 | Read strobe |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 16 | Handler program counter |
| new_bank | output | 8 | New program bank |
| new_status | output | 8 | Adjusted status byte |
| new_sp | output | 16 | Stack pointer after pushes |
| cycle_cost | output | 4 | Added cycle cost of the entry |

## Verification
A state machine in the wrong state appears within a cycle at the memory port. It shows up as a missing, repeated or misordered push, a stray vector read, or a strobe during idle. The scoreboard catches each of these at the access where it happens. A stack pointer that is wrong, or that is stepped on the wrong byte, gives a wrong write address on the first or the wrapping push. A flaw in the captured context or the result registers only appears at the done pulse, as a wrong pc, status, sp or cost, or as done arriving a cycle early or late.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PBANK,
        ST_PCH,
        ST_PCL,
        ST_PSTAT,
        ST_VLO,
        ST_VHI,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic        emu;
        logic        ovr;
        logic [15:0] pc;
        logic [7:0]  bank;
        logic [7:0]  status;
        logic [15:0] ovr_word;
    } irq_ctx_t;

    localparam int STAT_IRQ_BIT = 2;
    localparam int STAT_DEC_BIT = 3;

    function automatic logic [7:0] entry_status(input logic [7:0] s);
        logic [7:0] r;
        r = s;
        r[STAT_DEC_BIT] = 1'b0;
        r[STAT_IRQ_BIT] = 1'b1;
        return r;
    endfunction

    function automatic logic is_push(input seq_state_e s);
        return (s == ST_PBANK) || (s == ST_PCH) || (s == ST_PCL) || (s == ST_PSTAT);
    endfunction

endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       start_emu,
    input  logic       ctx_ovr,
    output seq_state_e state,
    output seq_state_e next_state
);
    always_comb begin
        next_state = state;
        case (state)
            ST_IDLE:  if (start) next_state = start_emu ? ST_PCH : ST_PBANK;
            ST_PBANK: next_state = ST_PCH;
            ST_PCH:   next_state = ST_PCL;
            ST_PCL:   next_state = ST_PSTAT;
            ST_PSTAT: next_state = ctx_ovr ? ST_DONE : ST_VLO;
            ST_VLO:   next_state = ST_VHI;
            ST_VHI:   next_state = ST_DONE;
            ST_DONE:  next_state = ST_IDLE;
            default:  next_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= next_state;
    end

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |=> (state == ST_IDLE));
endmodule

// File: rtl/irq_seq_stack.sv
module irq_seq_stack
    import irq_seq_pkg::*;
#(
    parameter int         AW         = 16,
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          load_emu,
    input  logic [AW-1:0] sp_in,
    input  seq_state_e    state,
    input  irq_ctx_t      ctx,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] sp_now
);
    logic [AW-1:0] sp_q;
    logic [7:0]    low_dec;

    assign low_dec = sp_q[7:0] - 8'd1;
    assign wr_en   = is_push(state);
    assign wr_addr = sp_q;
    assign sp_now  = sp_q;

    always_comb begin
        case (state)
            ST_PBANK: wr_data = ctx.bank;
            ST_PCH:   wr_data = ctx.pc[15:8];
            ST_PCL:   wr_data = ctx.pc[7:0];
            ST_PSTAT: wr_data = ctx.status;
            default:  wr_data = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else if (load) begin
            sp_q <= load_emu ? {STACK_PAGE, sp_in[7:0]} : sp_in;
        end else if (wr_en) begin
            sp_q <= ctx.emu ? {STACK_PAGE, low_dec} : sp_q - 1'b1;
        end
    end

    // R2
    emu_page_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ctx.emu) |-> (wr_addr[AW-1:8] == STACK_PAGE));
    // R1
    push_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && $past(wr_en)) |-> (wr_addr[7:0] == $past(wr_addr[7:0]) - 8'd1));
endmodule

// File: rtl/irq_seq_vector.sv
module irq_seq_vector
    import irq_seq_pkg::*;
#(
    parameter int            AW         = 16,
    parameter logic [AW-1:0] VEC_NATIVE = 16'hFFEE,
    parameter logic [AW-1:0] VEC_EMU    = 16'hFFFE
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_state_e    state,
    input  irq_ctx_t      ctx,
    input  logic [7:0]    rdata,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic [15:0]   vec_word
);
    logic [AW-1:0] base;
    logic [7:0]    lo_q;

    assign base     = ctx.emu ? VEC_EMU : VEC_NATIVE;
    assign rd_en    = (state == ST_VLO) || (state == ST_VHI);
    assign rd_addr  = (state == ST_VHI) ? base + 1'b1 : base;
    assign vec_word = ctx.ovr ? ctx.ovr_word : {rdata, lo_q};

    always_ff @(posedge clk) begin
        if (rst)                  lo_q <= 8'h00;
        else if (state == ST_VLO) lo_q <= rdata;
    end

    // R3
    vec_order_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_VHI) |-> ($past(rd_en) && rd_addr == $past(rd_addr) + 1'b1));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int         AW          = 16,
    parameter int         COST_W      = 4,
    parameter int         OVR_BIT     = 6,
    parameter logic [7:0] STACK_PAGE  = 8'h01,
    parameter logic [AW-1:0] VEC_NATIVE = 16'hFFEE,
    parameter logic [AW-1:0] VEC_EMU    = 16'hFFFE,
    parameter int         COST_NATIVE = 8,
    parameter int         COST_EMU    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              emu_mode,
    input  logic [15:0]       pc_in,
    input  logic [7:0]        bank_in,
    input  logic [7:0]        status_in,
    input  logic [AW-1:0]     sp_in,
    input  logic              ovr_en,
    input  logic [7:0]        ovr_ctrl,
    input  logic [7:0]        ovr_lo,
    input  logic [7:0]        ovr_hi,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr_en,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [15:0]       new_pc,
    output logic [7:0]        new_bank,
    output logic [7:0]        new_status,
    output logic [AW-1:0]     new_sp,
    output logic [COST_W-1:0] cycle_cost
);
    localparam logic [COST_W-1:0] C_NAT = COST_W'(COST_NATIVE);
    localparam logic [COST_W-1:0] C_EMU = COST_W'(COST_EMU);

    seq_state_e    state, next_state;
    irq_ctx_t      ctx;
    logic          accept, finish;
    logic          wr_en, rd_en;
    logic [AW-1:0] wr_addr, rd_addr, sp_now;
    logic [7:0]    wr_data;
    logic [15:0]   vec_word;

    assign accept = (state == ST_IDLE) && start;
    assign finish = (next_state == ST_DONE) && (state != ST_DONE);

    irq_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start), .start_emu(emu_mode),
        .ctx_ovr(ctx.ovr), .state(state), .next_state(next_state)
    );

    irq_seq_stack #(.AW(AW), .STACK_PAGE(STACK_PAGE)) u_stack (
        .clk(clk), .rst(rst), .load(accept), .load_emu(emu_mode), .sp_in(sp_in),
        .state(state), .ctx(ctx), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sp_now(sp_now)
    );

    irq_seq_vector #(.AW(AW), .VEC_NATIVE(VEC_NATIVE), .VEC_EMU(VEC_EMU)) u_vec (
        .clk(clk), .rst(rst), .state(state), .ctx(ctx), .rdata(mem_rdata),
        .rd_en(rd_en), .rd_addr(rd_addr), .vec_word(vec_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= '0;
        end else if (accept) begin
            ctx.emu      <= emu_mode;
            ctx.ovr      <= ovr_en & ovr_ctrl[OVR_BIT];
            ctx.pc       <= pc_in;
            ctx.bank     <= bank_in;
            ctx.status   <= status_in;
            ctx.ovr_word <= {ovr_hi, ovr_lo};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            new_pc     <= '0;
            new_bank   <= '0;
            new_status <= '0;
            new_sp     <= '0;
            cycle_cost <= '0;
        end else if (finish) begin
            new_pc     <= vec_word;
            new_bank   <= 8'h00;
            new_status <= entry_status(ctx.status);
            new_sp     <= ctx.ovr ? (ctx.emu ? {STACK_PAGE, sp_now[7:0] - 8'd1} : sp_now - 1'b1) : sp_now;
            cycle_cost <= ctx.emu ? C_EMU : C_NAT;
        end
    end

    assign mem_wr_en = wr_en;
    assign mem_rd_en = rd_en;
    assign mem_addr  = wr_en ? wr_addr : rd_addr;
    assign mem_wdata = wr_data;
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);

    // R9
    one_access_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr_en && mem_rd_en));
    // R4
    no_read_ovr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> !ctx.ovr);
    // R5
    result_flags_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (new_bank == 8'h00 && new_status[STAT_IRQ_BIT] && !new_status[STAT_DEC_BIT]));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, emu_mode = 1'b0, ovr_en = 1'b0;
    logic [15:0] pc_in = '0, sp_in = '0;
    logic [7:0]  bank_in = '0, status_in = '0, ovr_ctrl = '0, ovr_lo = '0, ovr_hi = '0;
    logic [7:0]  mem_rdata;
    logic        mem_wr_en, mem_rd_en, busy, done;
    logic [15:0] mem_addr, new_pc, new_sp;
    logic [7:0]  mem_wdata, new_bank, new_status;
    logic [3:0]  cycle_cost;

    localparam logic [7:0] SEED = 8'h5C;
    int checks = 0, fails = 0;
    bit finished = 0;

    typedef struct { bit wr; logic [15:0] addr; logic [7:0] data; string tag; } acc_t;
    acc_t expq[$];

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_model(input logic [15:0] a);
        return a[7:0] ^ SEED;
    endfunction
    assign mem_rdata = mem_model(mem_addr);

    irq_entry_seq uut (
        .clk(clk), .rst(rst), .start(start), .emu_mode(emu_mode), .pc_in(pc_in),
        .bank_in(bank_in), .status_in(status_in), .sp_in(sp_in), .ovr_en(ovr_en),
        .ovr_ctrl(ovr_ctrl), .ovr_lo(ovr_lo), .ovr_hi(ovr_hi), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy), .done(done), .new_pc(new_pc),
        .new_bank(new_bank), .new_status(new_status), .new_sp(new_sp),
        .cycle_cost(cycle_cost)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected accesses as the design issues them
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (mem_wr_en && mem_rd_en)
                check(0, "R9 dual strobe", 32'h1, 32'h0);
            else if (mem_wr_en || mem_rd_en) begin
                if (expq.size() == 0)
                    check(0, "R9 unexpected access", {15'h0, mem_wr_en, mem_addr}, 32'h0);
                else begin
                    acc_t e;
                    e = expq.pop_front();
                    check(mem_wr_en == e.wr && mem_addr == e.addr, {e.tag, " access"},
                          {15'h0, mem_wr_en, mem_addr}, {15'h0, e.wr, e.addr});
                    if (e.wr) check(mem_wdata == e.data, {e.tag, " data"}, mem_wdata, e.data);
                end
            end
        end
    end

    function automatic logic [15:0] step_sp(input bit emu, input logic [15:0] a);
        return emu ? {8'h01, a[7:0] - 8'd1} : a - 16'd1;
    endfunction

    task automatic run_case(input bit emu, input logic [15:0] pc, input logic [7:0] bank,
                            input logic [7:0] st, input logic [15:0] sp, input bit oe,
                            input logic [7:0] oc, input logic [7:0] ol, input logic [7:0] oh,
                            input bit poke);
        logic [15:0] a, vb, exp_pc;
        logic [7:0]  exp_st;
        bit use_ovr;
        int n, cyc;
        string pt;
        pt = emu ? "R2" : "R1";
        a = emu ? {8'h01, sp[7:0]} : sp;
        n = 0;
        if (!emu) begin expq.push_back('{1, a, bank, pt}); a = step_sp(emu, a); n++; end
        expq.push_back('{1, a, pc[15:8], pt}); a = step_sp(emu, a); n++;
        expq.push_back('{1, a, pc[7:0], pt});  a = step_sp(emu, a); n++;
        expq.push_back('{1, a, st, pt});       a = step_sp(emu, a); n++;
        use_ovr = oe && oc[6];
        vb = emu ? 16'hFFFE : 16'hFFEE;
        if (use_ovr) exp_pc = {oh, ol};
        else begin
            expq.push_back('{0, vb, 8'h00, "R3"});
            expq.push_back('{0, vb + 16'd1, 8'h00, "R3"});
            n += 2;
            exp_pc = {mem_model(vb + 16'd1), mem_model(vb)};
        end
        exp_st = (st & 8'hF7) | 8'h04;

        @(negedge clk);
        emu_mode = emu; pc_in = pc; bank_in = bank; status_in = st; sp_in = sp;
        ovr_en = oe; ovr_ctrl = oc; ovr_lo = ol; ovr_hi = oh; start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 1) begin
                // R9: restart request and new context while busy
                pc_in = ~pc; emu_mode = ~emu; sp_in = ~sp; bank_in = ~bank;
            end
            if (!poke || cyc >= 3) start = 1'b0;
        end while (!done && cyc < 40);

        check(cyc == n + 1, "R8 latency", cyc, n + 1);
        check(new_pc == exp_pc, use_ovr ? "R4 pc" : "R3 pc", new_pc, exp_pc);
        check(new_bank == 8'h00, "R5 bank", new_bank, 0);
        check(new_status == exp_st, "R5 status", new_status, exp_st);
        check(new_sp == a, "R7 sp", new_sp, a);
        check(cycle_cost == (emu ? 4'd6 : 4'd8), "R6 cost", cycle_cost, emu ? 6 : 8);
        check(expq.size() == 0, "R8 missing accesses", expq.size(), 0);
        @(negedge clk);
        check(!done && !busy, "R8 done pulse", {done, busy}, 0);
        check(!mem_wr_en && !mem_rd_en, "R9 idle after", {mem_wr_en, mem_rd_en}, 0);
        expq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10
        check(!busy && !done, "R10 reset status", {busy, done}, 0);
        check(!mem_wr_en && !mem_rd_en, "R10 reset strobes", {mem_wr_en, mem_rd_en}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy, "R10 idle after reset", busy, 0);
        run_case(0, 16'h1234, 8'h7E, 8'h0F, 16'h01FF, 0, 8'h00, 8'h00, 8'h00, 0);
        run_case(1, 16'hABCD, 8'h33, 8'hF8, 16'h0101, 0, 8'h00, 8'h00, 8'h00, 0);
        run_case(0, 16'h8000, 8'h12, 8'h00, 16'h0002, 1, 8'h40, 8'h9A, 8'h57, 0);
        run_case(1, 16'h4321, 8'h00, 8'hFF, 16'h0180, 1, 8'hBF, 8'h11, 8'h22, 0);
        run_case(0, 16'h0F0F, 8'hC0, 8'h2C, 16'h1F00, 0, 8'hFF, 8'h11, 8'h22, 0);
        run_case(1, 16'h7654, 8'h00, 8'h08, 16'h0103, 1, 8'h40, 8'hEF, 8'hBE, 0);
        run_case(0, 16'hBEEF, 8'h05, 8'h4B, 16'h0150, 0, 8'h00, 8'h00, 8'h00, 1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule